// File: doc/BRIEF.md
# Stereo Auto-DMA Sample Writer

This block sits between a DMA channel's FIFO and a halfword-addressed sound RAM. Each accepted 16-bit halfword is written to one of two fixed buffer regions. The first 256 halfwords go to the left region and the next 256 go to the right region, and this alternation repeats. The write address is the region base plus the position of the halfword inside its current block, taken modulo 2^20 halfwords.

A small control register holds the auto-DMA run bits. The block accepts data only while the bit picked by its core number is set. When a halfword closes a block, the block does three things: it pulses a stop request and a completion-interrupt request toward the feeding channel, it raises its need-data flag, and it clears the two low run bits so that it halts. Software then re-arms the block by writing the control register again.

The input is a valid/ready stream. `s_ready` follows only the run bit, so the producer may hold `s_valid` high for any length of time. A halfword moves on any clock edge where both are high, and at most one moves per clock. The RAM write port has no back-pressure: every write appears as a one-cycle `ram_we` pulse, one cycle after the halfword is accepted.

Top module: `stereo_adma_writer`

## Requirements
- R1: `s_ready` is high exactly when bit (CORE_ID) of the control register is set, that is, when the register ANDed with (CORE_ID+1) is non-zero. While `s_ready` is low, no halfword is accepted and `ram_we` stays low.
- R2: If the block is enabled and `s_valid` is low at an edge, `need_data` is 1 after that edge and no RAM write follows.
- R3: A halfword accepted at an edge appears one cycle later on `ram_wdata`, with `ram_we` high. Unless that halfword closes a block, `need_data` becomes 0 at the same edge.
- R4: The running transfer offset picks the region: when bit 8 of the offset is 0 the write goes to LEFT_BASE, otherwise to RIGHT_BASE. The address is the region base plus offset bits [7:0].
- R5: The write address wraps modulo 2^20 (20-bit halfword address).
- R6: The offset advances by exactly one for each accepted halfword. It holds through idle cycles and through cycles where the block is disabled.
- R7: When the accepted halfword brings the offset to a multiple of 256, `need_data` is 1 after that edge, and `dma_stop` and `dma_done_irq` are high for exactly that one cycle.
- R8: At that same boundary, control-register bits [1:0] become 0 and the other bits keep their value. This holds even when software writes the register in the same cycle; software's upper bits are kept.
- R9: Reset clears the offset and the control register, sets `need_data` to 1, and holds `ram_we`, `dma_stop` and `dma_done_irq` low.
- R10: A software write to the control register (`ctl_we`) shows on `ctl_rdata` from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | FIFO halfword available |
| s_ready | output | 1 | Block takes a halfword this cycle |
| s_data | input | 16 | FIFO halfword |
| ram_we | output | 1 | Sound RAM write strobe |
| ram_addr | output | 20 | Sound RAM halfword address |
| ram_wdata | output | 16 | Sound RAM write data |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 16 | Control register write value |
| ctl_rdata | output | 16 | Control register contents |
| need_data | output | 1 | Need-data status flag |
| dma_stop | output | 1 | One-cycle request to clear the channel's start bit |
| dma_done_irq | output | 1 | One-cycle request to set the channel's completion interrupt bit |

## Verification
The bench builds the block with CORE_ID = 1, so the enable bit is bit 1. Writing only bit 0 must therefore leave the input stalled, which shows that the core number selects the bit. LEFT_BASE is set to 0xFFFC0, which makes the left block cross the top of the 20-bit space partway through, so the modulo wrap is exercised. RIGHT_BASE sits far from the left region, so any mix-up between the two regions shows in the address. The default 256-halfword block is kept, so the bench runs real block boundaries. A third block then checks that striping returns to the left region.

// File: rtl/adma_pkg.sv
package adma_pkg;
  localparam int HW_W   = 16;   // sample halfword width
  localparam int RAM_AW = 20;   // halfword address: 2 MB sound RAM

  typedef logic [HW_W-1:0]   hword_t;
  typedef logic [RAM_AW-1:0] ram_addr_t;

  typedef struct packed {
    ram_addr_t addr;
    hword_t    data;
  } ram_wr_t;
endpackage

// File: rtl/adma_status_reg.sv
// Auto-DMA run register: software-writable, self-clearing run bits at block end.
module adma_status_reg #(
  parameter int CORE_ID = 0,
  parameter int W       = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sw_we,
  input  logic [W-1:0] sw_wdata,
  input  logic         clr_run,
  output logic [W-1:0] stat,
  output logic         run_en
);
  localparam logic [W-1:0] MASK = W'(CORE_ID + 1);

  logic [W-1:0] hit;
  logic [W-1:0] nxt;

  // One match term per bit; only the mask bits survive.
  for (genvar b = 0; b < W; b++) begin : g_hit
    assign hit[b] = stat[b] & MASK[b];
  end
  assign run_en = |hit;

  always_comb begin
    nxt = sw_we ? sw_wdata : stat;
    if (clr_run) nxt[1:0] = 2'b00;   // block end wins over software
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stat <= '0;
    else        stat <= nxt;
  end
endmodule

// File: rtl/adma_offset_ctr.sv
// Transfer offset: position within block plus left/right side bit.
module adma_offset_ctr #(
  parameter int BLOCK_HW = 256
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        step,
  output logic [$clog2(BLOCK_HW)-1:0] pos,
  output logic                        side_right,
  output logic                        blk_end
);
  localparam int BLK_W = $clog2(BLOCK_HW);
  localparam int OFS_W = BLK_W + 1;

  logic [OFS_W-1:0] ofs;

  assign pos        = ofs[BLK_W-1:0];
  assign side_right = ofs[BLK_W];
  // The step that fills the last slot takes the offset to a block multiple.
  assign blk_end    = step & (&ofs[BLK_W-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n)    ofs <= '0;
    else if (step) ofs <= ofs + OFS_W'(1);
  end
endmodule

// File: rtl/adma_addr_map.sv
// Fixed-base address map for the striped stereo buffers.
module adma_addr_map
  import adma_pkg::*;
#(
  parameter ram_addr_t LEFT_BASE  = 20'h02000,
  parameter ram_addr_t RIGHT_BASE = 20'h02200,
  parameter int        BLK_W      = 8
) (
  input  logic [BLK_W-1:0] pos,
  input  logic             side_right,
  output ram_addr_t        addr
);
  ram_addr_t base;
  ram_addr_t pos_ext;

  assign base    = side_right ? RIGHT_BASE : LEFT_BASE;
  assign pos_ext = {{(RAM_AW-BLK_W){1'b0}}, pos};
  assign addr    = base + pos_ext;   // truncation gives modulo 2^RAM_AW
endmodule

// File: rtl/stereo_adma_writer.sv
module stereo_adma_writer
  import adma_pkg::*;
#(
  parameter int        CORE_ID    = 0,
  parameter ram_addr_t LEFT_BASE  = 20'h02000,
  parameter ram_addr_t RIGHT_BASE = 20'h02200,
  parameter int        BLOCK_HW   = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [HW_W-1:0]   s_data,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [HW_W-1:0]   ram_wdata,
  input  logic              ctl_we,
  input  logic [HW_W-1:0]   ctl_wdata,
  output logic [HW_W-1:0]   ctl_rdata,
  output logic              need_data,
  output logic              dma_stop,
  output logic              dma_done_irq
);
  localparam int BLK_W = $clog2(BLOCK_HW);

  logic             run_en;
  logic             accept;
  logic             blk_end;
  logic [BLK_W-1:0] pos;
  logic             side_right;
  ram_addr_t        map_addr;
  ram_wr_t          wr_q;

  assign s_ready = run_en;
  assign accept  = s_valid & run_en;

  adma_status_reg #(.CORE_ID(CORE_ID), .W(HW_W)) u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .sw_we    (ctl_we),
    .sw_wdata (ctl_wdata),
    .clr_run  (blk_end),
    .stat     (ctl_rdata),
    .run_en   (run_en)
  );

  adma_offset_ctr #(.BLOCK_HW(BLOCK_HW)) u_ofs (
    .clk        (clk),
    .rst_n      (rst_n),
    .step       (accept),
    .pos        (pos),
    .side_right (side_right),
    .blk_end    (blk_end)
  );

  adma_addr_map #(.LEFT_BASE(LEFT_BASE), .RIGHT_BASE(RIGHT_BASE), .BLK_W(BLK_W)) u_map (
    .pos        (pos),
    .side_right (side_right),
    .addr       (map_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ram_we       <= 1'b0;
      wr_q         <= '0;
      need_data    <= 1'b1;
      dma_stop     <= 1'b0;
      dma_done_irq <= 1'b0;
    end else begin
      ram_we       <= accept;
      dma_stop     <= blk_end;
      dma_done_irq <= blk_end;
      if (accept) wr_q <= '{addr: map_addr, data: s_data};
      // Flag tracks the last attempt; a block end re-raises it.
      if (run_en) need_data <= ~s_valid | blk_end;
    end
  end

  assign ram_addr  = wr_q.addr;
  assign ram_wdata = wr_q.data;
endmodule

// File: rtl/stereo_adma_writer_chk.sv
module stereo_adma_writer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        s_valid,
  input logic        s_ready,
  input logic [15:0] s_data,
  input logic        ram_we,
  input logic [15:0] ram_wdata,
  input logic [15:0] ctl_rdata,
  input logic        need_data,
  input logic        dma_stop,
  input logic        dma_done_irq
);
  assert_stall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && !s_ready) |=> !ram_we);

  assert_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ready && !s_valid) |=> (need_data && !ram_we));

  assert_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> (ram_we && ram_wdata == $past(s_data)));

  assert_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dma_stop |-> (need_data && dma_done_irq && ram_we));

  assert_oneshot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dma_stop |=> !dma_stop);

  assert_runoff_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dma_stop |-> (ctl_rdata[1:0] == 2'b00));
endmodule

bind stereo_adma_writer stereo_adma_writer_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .s_valid      (s_valid),
  .s_ready      (s_ready),
  .s_data       (s_data),
  .ram_we       (ram_we),
  .ram_wdata    (ram_wdata),
  .ctl_rdata    (ctl_rdata),
  .need_data    (need_data),
  .dma_stop     (dma_stop),
  .dma_done_irq (dma_done_irq)
);

// File: tb/sim_stereo_adma_writer.sv
`timescale 1ns/1ps
module sim_stereo_adma_writer;
  localparam logic [19:0] LB = 20'hFFFC0;
  localparam logic [19:0] RB = 20'h40000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [15:0] s_data = '0;
  logic        ram_we;
  logic [19:0] ram_addr;
  logic [15:0] ram_wdata;
  logic        ctl_we = 1'b0;
  logic [15:0] ctl_wdata = '0;
  logic [15:0] ctl_rdata;
  logic        need_data;
  logic        dma_stop;
  logic        dma_done_irq;

  int n_chk = 0;
  int n_bad = 0;
  int exp_ofs = 0;
  bit done = 0;

  always #10 clk = ~clk;   // 50 MHz

  stereo_adma_writer #(.CORE_ID(1), .LEFT_BASE(LB), .RIGHT_BASE(RB)) u0 (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .need_data(need_data), .dma_stop(dma_stop), .dma_done_irq(dma_done_irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one cycle at the falling edge; sample just after the rising edge.
  task automatic cycle(input logic v, input logic [15:0] d,
                       input logic we, input logic [15:0] wd);
    @(negedge clk);
    s_valid = v; s_data = d; ctl_we = we; ctl_wdata = wd;
    @(posedge clk); #1;
  endtask

  task automatic ctl_write(input logic [15:0] v);
    cycle(1'b0, 16'h0, 1'b1, v);
    chk("R10 ctl readback", ctl_rdata, v);
  endtask

  // One accepted halfword, checked against the model.
  task automatic push(input logic [15:0] d, input logic we, input logic [15:0] wd,
                      input logic [15:0] exp_stat);
    logic [19:0] ea;
    bit          bnd;
    ea  = (((exp_ofs & 256) != 0) ? RB : LB) + 20'(exp_ofs & 255);
    exp_ofs++;
    bnd = (exp_ofs % 256) == 0;
    chk("R1 ready before push", s_ready, 1);
    cycle(1'b1, d, we, wd);
    chk("R3 ram_we", ram_we, 1);
    chk("R3 ram_wdata", ram_wdata, d);
    chk("R4/R5 ram_addr", ram_addr, ea);
    chk("R3/R7 need_data", need_data, bnd);
    chk("R7 dma_stop", dma_stop, bnd);
    chk("R7 dma_done_irq", dma_done_irq, bnd);
    if (bnd) chk("R8 run bits cleared", ctl_rdata, exp_stat);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R9 need_data", need_data, 1);
    chk("R9 ram_we", ram_we, 0);
    chk("R9 stop", dma_stop, 0);
    chk("R9 irq", dma_done_irq, 0);
    chk("R9 ctl", ctl_rdata, 0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_gate;
    ctl_write(16'h0001);              // bit 0 is not this core's bit
    chk("R1 wrong bit stalls", s_ready, 0);
    for (int i = 0; i < 3; i++) begin
      cycle(1'b1, 16'hDEAD, 1'b0, 16'h0);
      chk("R1 no write when disabled", ram_we, 0);
      chk("R1 need_data held", need_data, 1);
    end
    ctl_write(16'h0002);
    chk("R1 own bit enables", s_ready, 1);
  endtask

  task automatic t_left_block;
    for (int i = 0; i < 255; i++) push(16'hA000 + 16'(i), 1'b0, 16'h0, 16'h0);
    // Software write collides with the boundary clear (R8).
    push(16'hA0FF, 1'b1, 16'h8003, 16'h8000);
    chk("R8 stalled after boundary", s_ready, 0);
    cycle(1'b1, 16'hBEEF, 1'b0, 16'h0);
    chk("R7 stop is one cycle", dma_stop, 0);
    chk("R7 irq is one cycle", dma_done_irq, 0);
    chk("R1 no write after halt", ram_we, 0);
  endtask

  task automatic t_right_gaps;
    ctl_write(16'hA5A6);
    for (int i = 0; i < 100; i++) push(16'h5000 + 16'(i), 1'b0, 16'h0, 16'h0);
    for (int g = 0; g < 3; g++) begin
      cycle(1'b0, 16'h0, 1'b0, 16'h0);
      chk("R2 need_data on empty", need_data, 1);
      chk("R2 no write on empty", ram_we, 0);
    end
    // Offset held through the gap (R6): addresses continue from 100.
    for (int i = 100; i < 256; i++) push(16'h5000 + 16'(i), 1'b0, 16'h0, 16'hA5A4);
    chk("R8 upper bits kept", ctl_rdata, 16'hA5A4);
  endtask

  task automatic t_resume_left;
    ctl_write(16'h0003);
    for (int i = 0; i < 4; i++) push(16'h3300 + 16'(i), 1'b0, 16'h0, 16'h0);
    chk("R4 third block back to left", ram_addr, LB + 20'd3);
    cycle(1'b0, 16'h0, 1'b0, 16'h0);
    chk("R6 offset at 516 -> ready", s_ready, 1);
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    t_reset();
    t_gate();
    t_left_block();
    t_right_gaps();
    t_resume_left();
    done = 1;
    finish_run();
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
    end
  end
endmodule